// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block decides where a memory access lands when it falls into one of the regions reserved for system management mode. It holds three configuration registers (an SMRAM control byte, an extended control byte and a 16-bit extended TSEG size register), reached through a simple write/read port. For every access it receives a physical address and a flag saying whether the processor is in system management mode. It returns a route: DRAM, the PCI/legacy video path, a sink that returns all ones on reads and drops writes, or "not claimed" when the address is outside the regions it governs.

Three regions are decoded. The first is the legacy 128 KB window at 0xA0000..0xBFFFF. The second is a high alias of that window at 0xFEDA0000..0xFEDBFFFF, which maps to the same DRAM. The third is a TSEG region that ends at the top of low memory, a static input. Firmware opens, closes and locks these regions through the control bytes. A lock bit freezes the configuration until reset. A query/reply handshake on the size register lets firmware discover the extended TSEG size built into the block.

Top module: `smm_route_ctl`

## Requirements
- R1: Port select codes are 0 = SMRAM control byte, 1 = extended control byte, 2 = extended size register, 3 = unused (reads 0, writes ignored). After reset they read 0x02, 0x38 and 0xFFFF respectively (0x0000 for the size register if the built-in extended size is 0). The route of a non-SMM access to 0xA0000 is PCI.
- R2: In the SMRAM byte, bit 6 is open, bit 5 is a spare writable bit, bit 4 is lock and bit 3 is global enable. Bits 2:0 are fixed at 010 and bit 7 reads 0. In the extended byte, bit 7 is high-select, bits 2:1 are the TSEG size code and bit 0 is TSEG enable. Bits 5:3 are fixed at 1 and bit 6 reads 0. Writes take effect on the cycle after the write edge.
- R3: Once a write leaves lock at 1, open is forced to 0 by that same write. Lock stays 1 until reset. Only bit 5 of the SMRAM byte stays writable, and the extended byte is frozen.
- R4: Route codes are 00 none, 01 DRAM, 10 PCI, 11 sink. A non-SMM access to the low window goes to DRAM when open=1 and high-select=0, and to PCI otherwise.
- R5: A non-SMM access to the high alias goes to DRAM when open=1 and high-select=1, and is not claimed (none) otherwise.
- R6: With global enable set, an SMM access goes to DRAM in the low window when high-select=0, and in the high alias when high-select=1. In every other case an SMM access to a window is routed as a non-SMM access would be.
- R7: With TSEG enable set, the size code gives 1 MB (00), 2 MB (01), 8 MB (10) or the built-in extended size in MB (11). With TSEG enable clear, the size is 0.
- R8: Addresses in [top - size, top) go to the sink for non-SMM accesses and to DRAM for SMM accesses. Here top is the top-of-low-memory input.
- R9: A write of 0xFFFF to the size register stores the built-in extended size instead, provided that size is nonzero. Any other value is stored as written.
- R10: The error output is high exactly when the built-in extended size exceeds 0xFFF MB.
- R11: Addresses outside all three regions return none. Where TSEG overlaps a legacy window, the window decode takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select |
| cfgWrData | input | 16 | Write data (bytes use bits 7:0) |
| cfgRdData | output | 16 | Read data of the selected register |
| tolm | input | ADDR_W | Top of low memory (static) |
| reqAddr | input | ADDR_W | Access address |
| reqSmm | input | 1 | Access is made in system management mode |
| reqRoute | output | 2 | Route code |
| cfgErr | output | 1 | Built-in extended size out of range |

## Verification
Assertions check the following on every cycle:
- lock stays sticky, keeps open at 0 and freezes the extended byte;
- a query write is answered on the next cycle;
- SMM accesses inside TSEG always reach DRAM;
- a locked low window routes non-SMM traffic to PCI;
- the high alias stays unclaimed while closed.

The bench sweeps every combination of open, global enable, high-select, TSEG enable and size code. For each combination it probes each region's first and last bytes and the bytes just beside them, in both modes. Only this sweep shows that the size decode, the region bounds and the precedence between regions are arithmetically right. The write masks, the ordering inside a locking write and the handshake values are also shown only by the bench's directed scenarios.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_DRAM = 2'b01,
    RT_PCI  = 2'b10,
    RT_SINK = 2'b11
  } route_e;

  // Decoded control strobes handed from the register block to the decoder
  typedef struct packed {
    logic       openWin;
    logic       locked;
    logic       smmGlobalEn;
    logic       highSel;
    logic       tsegEn;
    logic [1:0] tsegCode;
  } ctlStrobes_t;

  localparam logic [1:0] SEL_SMC = 2'd0;
  localparam logic [1:0] SEL_XSC = 2'd1;
  localparam logic [1:0] SEL_XSZ = 2'd2;

  localparam int BIT_OPEN  = 6;
  localparam int BIT_LOCK  = 4;
  localparam int BIT_GEN   = 3;
  localparam int BIT_HSEL  = 7;
  localparam int BIT_TEN   = 0;

  localparam logic [7:0] SMC_RESET       = 8'h02;
  localparam logic [7:0] SMC_MASK_OPEN   = 8'h78;
  localparam logic [7:0] SMC_MASK_LOCKED = 8'h20;
  localparam logic [7:0] XSC_RESET       = 8'h38;
  localparam logic [7:0] XSC_MASK_OPEN   = 8'h87;
  localparam logic [7:0] XSC_MASK_LOCKED = 8'h00;
endpackage

// File: rtl/smm_cfg_ctl.sv
module smm_cfg_ctl
  import smm_pkg::*;
#(
  parameter int          EXT_MB = 16,
  parameter logic [15:0] QUERY  = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [1:0]  sel,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output ctlStrobes_t strobes
);
  localparam logic [15:0] EXT_MB16  = 16'(EXT_MB);
  localparam logic [15:0] XSZ_RESET = (EXT_MB > 0) ? QUERY : 16'h0000;

  logic [7:0]  smcQ, xscQ, smcD, xscD, smcMask, xscMask;
  logic [15:0] xszQ, xszD;
  logic        lockQ;

  assign lockQ   = smcQ[BIT_LOCK];
  assign smcMask = lockQ ? SMC_MASK_LOCKED : SMC_MASK_OPEN;
  assign xscMask = lockQ ? XSC_MASK_LOCKED : XSC_MASK_OPEN;

  always_comb begin
    smcD = smcQ;
    xscD = xscQ;
    xszD = xszQ;
    if (wrEn) begin
      unique case (sel)
        SEL_SMC: smcD = (smcQ & ~smcMask) | (wrData[7:0] & smcMask);
        SEL_XSC: xscD = (xscQ & ~xscMask) | (wrData[7:0] & xscMask);
        SEL_XSZ: xszD = ((EXT_MB > 0) && (wrData == QUERY)) ? EXT_MB16 : wrData;
        default: ;
      endcase
    end
    // a lock that lands closes the window in the same update
    if (smcD[BIT_LOCK]) smcD[BIT_OPEN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smcQ <= SMC_RESET;
      xscQ <= XSC_RESET;
      xszQ <= XSZ_RESET;
    end else begin
      smcQ <= smcD;
      xscQ <= xscD;
      xszQ <= xszD;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_SMC: rdData = {8'h00, smcQ};
      SEL_XSC: rdData = {8'h00, xscQ};
      SEL_XSZ: rdData = xszQ;
      default: rdData = 16'h0000;
    endcase
  end

  assign strobes.openWin     = smcQ[BIT_OPEN];
  assign strobes.locked      = lockQ;
  assign strobes.smmGlobalEn = smcQ[BIT_GEN];
  assign strobes.highSel     = xscQ[BIT_HSEL];
  assign strobes.tsegEn      = xscQ[BIT_TEN];
  assign strobes.tsegCode    = xscQ[2:1];

  // R3: lock is sticky, keeps the window closed and freezes the extended byte
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lockQ |=> lockQ);
  p_locked_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lockQ |-> !smcQ[BIT_OPEN]);
  p_ext_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lockQ |=> $stable(xscQ));

  // R2: an unlocked write of the open bit shows on the next cycle
  p_open_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && sel == SEL_SMC && !lockQ && !wrData[BIT_LOCK])
      |=> smcQ[BIT_OPEN] == $past(wrData[BIT_OPEN]));

  generate
    if (EXT_MB > 0) begin : g_query
      // R9: a query write is answered with the built-in size
      p_query_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrEn && sel == SEL_XSZ && wrData == QUERY) |=> xszQ == EXT_MB16);
    end
  endgenerate
endmodule

// File: rtl/smm_route_dp.sv
module smm_route_dp
  import smm_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                EXT_MB    = 16,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 'hFEDA_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] tolm,
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  output route_e            route
);
  localparam int MB_SHIFT = 20;

  logic [ADDR_W-1:0] tsegMb, tsegBytes;
  logic              inLow, inHigh, inTseg;
  route_e            plainRoute;

  always_comb begin
    unique case (ctl.tsegCode)
      2'b00:   tsegMb = ADDR_W'(1);
      2'b01:   tsegMb = ADDR_W'(2);
      2'b10:   tsegMb = ADDR_W'(8);
      default: tsegMb = ADDR_W'(EXT_MB);
    endcase
  end

  assign tsegBytes = ctl.tsegEn ? (tsegMb << MB_SHIFT) : '0;
  assign inLow  = (addr >= LOW_BASE)  && (addr - LOW_BASE  < WIN_SIZE);
  assign inHigh = (addr >= HIGH_BASE) && (addr - HIGH_BASE < WIN_SIZE);
  assign inTseg = (tsegBytes != '0) && (addr < tolm) && ((tolm - addr) <= tsegBytes);

  // Route as seen by ordinary (non-SMM) traffic
  always_comb begin
    if (inLow)
      plainRoute = (ctl.openWin && !ctl.highSel) ? RT_DRAM : RT_PCI;
    else if (inHigh)
      plainRoute = (ctl.openWin && ctl.highSel) ? RT_DRAM : RT_NONE;
    else if (inTseg)
      plainRoute = RT_SINK;
    else
      plainRoute = RT_NONE;
  end

  // SMM view overlays the ordinary one
  always_comb begin
    route = plainRoute;
    if (smm) begin
      if (inLow) begin
        if (ctl.smmGlobalEn && !ctl.highSel) route = RT_DRAM;
      end else if (inHigh) begin
        if (ctl.smmGlobalEn && ctl.highSel) route = RT_DRAM;
      end else if (inTseg) begin
        route = RT_DRAM;
      end
    end
  end

  // R8: SMM traffic inside TSEG always reaches DRAM
  p_smm_tseg_dram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smm && inTseg && !inLow && !inHigh) |-> route == RT_DRAM);
  // R4: once locked the low window belongs to PCI for ordinary traffic
  p_locked_low_pci_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!smm && inLow && ctl.locked) |-> route == RT_PCI);
  // R5: a closed high alias is never claimed for ordinary traffic
  p_high_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!smm && inHigh && !ctl.openWin) |-> route == RT_NONE);
endmodule

// File: rtl/smm_route_ctl.sv
module smm_route_ctl
  import smm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int EXT_MB = 16,
  parameter int MAX_MB = 'hFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [15:0]       cfgWrData,
  output logic [15:0]       cfgRdData,
  input  logic [ADDR_W-1:0] tolm,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  output logic [1:0]        reqRoute,
  output logic              cfgErr
);
  ctlStrobes_t ctlBus;
  route_e      routeW;

  smm_cfg_ctl #(.EXT_MB(EXT_MB)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wrEn(cfgWrEn), .sel(cfgSel),
    .wrData(cfgWrData), .rdData(cfgRdData), .strobes(ctlBus)
  );

  smm_route_dp #(.ADDR_W(ADDR_W), .EXT_MB(EXT_MB)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctlBus), .tolm(tolm),
    .addr(reqAddr), .smm(reqSmm), .route(routeW)
  );

  assign reqRoute = routeW;
  assign cfgErr   = (EXT_MB > MAX_MB);
endmodule

// File: tb/sim_smm_route_ctl.sv
module sim_smm_route_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TOLM = 32'h4000_0000;
  localparam int EXT = 16;

  logic        clk = 0, rst_n = 0, cfgWrEn = 0, reqSmm = 0;
  logic [1:0]  cfgSel = 0;
  logic [15:0] cfgWrData = 0, cfgRdData;
  logic [31:0] reqAddr = 0;
  logic [1:0]  reqRoute;
  logic        cfgErr;
  int nTests = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_route_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .tolm(TOLM),
    .reqAddr(reqAddr), .reqSmm(reqSmm), .reqRoute(reqRoute), .cfgErr(cfgErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cfgSel = s; cfgWrData = d; cfgWrEn = 1;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic cfgRead(input logic [1:0] s, output logic [15:0] d);
    cfgSel = s; #1; d = cfgRdData;
  endtask

  task automatic probe(input logic [31:0] a, input logic s, output logic [1:0] r);
    reqAddr = a; reqSmm = s; #1; r = reqRoute;
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  // Expected route from the requirements: 0 none, 1 DRAM, 2 PCI, 3 sink
  function automatic logic [1:0] expRoute(bit op, bit g, bit h, bit ten, bit [1:0] sz,
                                          logic [31:0] a, bit smm);
    longint unsigned mb, tsz;
    bit lowW, highW, tsW;
    mb  = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 8 : EXT;
    tsz = ten ? mb * 1048576 : 0;
    lowW  = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
    highW = (a >= 32'hFEDA_0000) && (a <= 32'hFEDB_FFFF);
    tsW   = (tsz != 0) && (longint'(a) >= longint'(TOLM) - longint'(tsz)) && (a < TOLM);
    if (lowW) return (smm && g && !h) ? 2'd1 : ((op && !h) ? 2'd1 : 2'd2);
    if (highW) return (smm && g && h) ? 2'd1 : ((op && h) ? 2'd1 : 2'd0);
    if (tsW) return smm ? 2'd1 : 2'd3;
    return 2'd0;
  endfunction

  function automatic string tagFor(logic [31:0] a, bit smm);
    bit lowW, highW;
    lowW  = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
    highW = (a >= 32'hFEDA_0000) && (a <= 32'hFEDB_FFFF);
    if ((lowW || highW) && smm) return "R6";
    if (lowW) return "R4";
    if (highW) return "R5";
    if (a < TOLM && a >= TOLM - 32'h0100_0001) return "R7 R8";
    return "R11";
  endfunction

  logic [31:0] probes [16];
  initial begin
    probes[0]  = 32'h0009_FFFF; probes[1]  = 32'h000A_0000;
    probes[2]  = 32'h000B_FFFF; probes[3]  = 32'h000C_0000;
    probes[4]  = 32'hFED9_FFFF; probes[5]  = 32'hFEDA_0000;
    probes[6]  = 32'hFEDB_FFFF; probes[7]  = 32'hFEDC_0000;
    probes[8]  = TOLM - 1;      probes[9]  = TOLM;
    probes[10] = TOLM - 32'h0010_0000; probes[11] = TOLM - 32'h0010_0001;
    probes[12] = TOLM - 32'h0020_0000; probes[13] = TOLM - 32'h0080_0000;
    probes[14] = TOLM - 32'h0100_0000; probes[15] = TOLM - 32'h0100_0001;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [1:0]  rt;
    doReset();

    // R1: reset state
    cfgRead(2'd0, rd); chk("R1 smram byte reset", rd, 16'h0002);
    cfgRead(2'd1, rd); chk("R1 ext byte reset", rd, 16'h0038);
    cfgRead(2'd2, rd); chk("R1 ext size reset", rd, 16'hFFFF);
    cfgRead(2'd3, rd); chk("R1 unused select", rd, 16'h0000);
    probe(32'h000A_0000, 0, rt); chk("R1 low window route", rt, 2'd2);
    chk("R10 error low", cfgErr, 1'b0);

    // R2: write masks
    cfgWrite(2'd1, 16'h00FF); cfgRead(2'd1, rd); chk("R2 ext byte mask", rd, 16'h00BF);
    cfgWrite(2'd0, 16'h00AF); cfgRead(2'd0, rd); chk("R2 smram byte mask", rd, 16'h002A);
    cfgWrite(2'd0, 16'h0000); cfgRead(2'd0, rd); chk("R2 smram clear", rd, 16'h0002);
    cfgWrite(2'd3, 16'hFFFF); cfgRead(2'd3, rd); chk("R1 unused write ignored", rd, 16'h0000);
    cfgRead(2'd0, rd); chk("R1 unused write no side effect", rd, 16'h0002);

    // Sweep every unlocked configuration
    for (int c = 0; c < 64; c++) begin
      bit op, g, h, ten;
      bit [1:0] sz;
      logic [7:0] smc, xsc;
      op = c[0]; g = c[1]; h = c[2]; ten = c[3]; sz = c[5:4];
      smc = {1'b0, op, 2'b00, g, 3'b000};
      xsc = {h, 4'b0000, sz, ten};
      cfgWrite(2'd0, {8'h00, smc});
      cfgWrite(2'd1, {8'h00, xsc});
      cfgRead(2'd0, rd); chk("R2 sweep smram readback", rd, {8'h00, smc | 8'h02});
      cfgRead(2'd1, rd); chk("R2 sweep ext readback", rd, {8'h00, xsc | 8'h38});
      for (int p = 0; p < 16; p++) begin
        for (int s = 0; s < 2; s++) begin
          probe(probes[p], s[0], rt);
          chk(tagFor(probes[p], s[0]), rt, expRoute(op, g, h, ten, sz, probes[p], s[0]));
        end
      end
    end

    // R9: query handshake
    cfgWrite(2'd2, 16'hFFFF); cfgRead(2'd2, rd); chk("R9 query reply", rd, 16'h0010);
    cfgWrite(2'd2, 16'h1234); cfgRead(2'd2, rd); chk("R9 plain store", rd, 16'h1234);
    cfgWrite(2'd2, 16'hFFFF); cfgRead(2'd2, rd); chk("R9 query again", rd, 16'h0010);

    // R3: lock behaviour
    cfgWrite(2'd0, 16'h0048);
    cfgWrite(2'd1, 16'h0087);
    cfgWrite(2'd0, 16'h0058); cfgRead(2'd0, rd); chk("R3 lock clears open", rd, 16'h001A);
    cfgWrite(2'd0, 16'h0068); cfgRead(2'd0, rd); chk("R3 locked mask spare only", rd, 16'h003A);
    cfgWrite(2'd0, 16'h0000); cfgRead(2'd0, rd); chk("R3 lock sticky", rd, 16'h001A);
    cfgWrite(2'd1, 16'h0000); cfgRead(2'd1, rd); chk("R3 ext byte frozen", rd, 16'h00BF);
    probe(32'h000A_0000, 0, rt); chk("R3 R4 locked low pci", rt, 2'd2);
    probe(32'hFEDA_0000, 0, rt); chk("R3 R5 locked high hidden", rt, 2'd0);
    probe(32'hFEDA_0000, 1, rt); chk("R3 R6 locked smm high", rt, 2'd1);
    probe(TOLM - 1, 0, rt);      chk("R3 R8 locked tseg sink", rt, 2'd3);
    probe(TOLM - 32'h0100_0000, 1, rt); chk("R3 R8 locked tseg smm", rt, 2'd1);

    // R1/R3: reset releases the lock
    doReset();
    cfgRead(2'd0, rd); chk("R3 reset unlocks", rd, 16'h0002);
    cfgRead(2'd2, rd); chk("R1 size query after reset", rd, 16'hFFFF);
    cfgWrite(2'd0, 16'h0040); cfgRead(2'd0, rd); chk("R3 open writable again", rd, 16'h0042);
    probe(32'h000B_FFFF, 0, rt); chk("R4 open low dram", rt, 2'd1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule